// File: doc/BRIEF.md
# Serial-Frame Power-Mode Controller for a Sampling Converter

This block is the digital control logic of a single-channel 14-bit sampling converter with a three-wire serial port. The port has an active-low frame select, a serial clock and one serial data line. The block runs on a fast system clock and oversamples the frame select and serial clock through a synchronizer. It counts the falling edges of the serial clock inside each frame, and the count at the moment the frame select rises decides the power state.

In normal mode there are two guard cases and one power-down window. A frame that ends before the second falling edge changes nothing. A frame that ends on or after the tenth edge also keeps the part running. A frame that ends between those two points shuts the part down.

While the part is shut down, a new frame starts waking it. The wake holds only if the frame stays open past the tenth falling edge. The part is declared fully powered once sixteen serial clock falls have been counted since the wake frame began. The frame that wakes the part and any frame opened before power is complete return invalid data. The first conversion opened afterwards is valid.

The conversion result arrives on a parallel input and is captured when a frame opens. It is shifted out most significant bit first, behind two zero bits. The data pin itself is meant for a pad cell outside this block: the block provides the data bit and a separate drive enable.

Top module: `adc_pd_ctrl`

## Requirements
- R1: After reset the part is powered (`powered`=1, `power_down`=0), `data_valid` is 0 and `sdo_oe` is 0.
- R2: `sdo_oe` is 1 while the frame select is low and 0 while it is high.
- R3: The result is captured at the falling edge of the frame select. The word sent is {2'b00, result}, most significant bit first. Before any clock fall, `sdo` shows word bit 15. After k serial clock falls (k = 1..15), `sdo` shows word bit 15-k.
- R4: In normal mode, a frame that ends with 0 or 1 serial clock falls leaves the part powered.
- R5: In normal mode, a frame that ends with 2 to 9 falls puts the part into power-down: `power_down`=1 and `powered`=0.
- R6: In normal mode, a frame that ends with 10 or more falls keeps the part powered. `data_valid` rises at the end of such a frame only if it saw at least 16 falls.
- R7: In power-down, a frame that ends with fewer than 10 falls returns the part to power-down. This includes a stray burst of 8 clocks.
- R8: A frame opened in power-down that ends with 10 or more falls commits the wake, so `power_down` goes to 0. `powered` rises only once 16 serial clock falls have been counted since that frame opened. Falls with the frame select high also count.
- R9: `data_valid` clears at every frame start. It stays 0 after a frame that was opened while the part was not fully powered.
- R10: The falling-edge count saturates at 16. A longer frame is treated as complete, and `sdo` shows 0 after the 16th fall.
- R11: Once a wake is committed, a short frame (2 to 9 falls) does not send the part back to power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data advances on its falling edge |
| result | input | 14 | Conversion result, sampled at frame start |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the data pad (0 = high impedance) |
| powered | output | 1 | Part fully powered |
| power_down | output | 1 | Part in power-down |
| data_valid | output | 1 | Last completed frame carried a valid result |

## Verification
Some properties are checked on every cycle by the assertions:
- the edge count never passes 16 and holds once saturated;
- power-down is never left directly for full power;
- a normal-mode shutdown only ever follows a frame select rise with a count of 2 to 9;
- a wake only completes once the wake timer is full;
- `data_valid` only rises at the end of a 16-edge frame;
- a loaded word always starts with a zero bit.

The serial bit order, the guard windows seen from the pins, wake completion by idle clocks, and the invalid-then-valid data sequence can only be shown by the bench. It runs directed frames of chosen lengths and random frame lengths, and checks them against a reference model of the power states.

// File: rtl/adc_pd_pkg.sv
// Package: shared types of the serial-frame power-mode controller.
// Assumes: nothing; pure type definitions.
package adc_pd_pkg;

    // Power states: running, shut down, wake frame still in its guard
    // window, and wake committed but waiting for the wake timer.
    typedef enum logic [1:0] {
        PS_ON     = 2'd0,
        PS_DOWN   = 2'd1,
        PS_GUARD  = 2'd2,
        PS_WAKING = 2'd3
    } pwr_state_t;

endpackage

// File: rtl/adc_pd_sync.sv
// Module: multi-bit level synchronizer with edge detection.
// Does: passes N asynchronous inputs through STAGES flops, then flags
//       rising and falling edges of the synchronized level for one cycle.
// Assumes: each input stays stable for longer than STAGES+1 clk cycles.
module adc_pd_sync #(
    parameter int              N       = 2,
    parameter int              STAGES  = 2,
    parameter logic [N-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] pipe [STAGES];
    logic [N-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: capture the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= din;
            end
        end else begin : g_next
            // Later flops: move the sample down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    // Keep last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= pipe[STAGES-1];
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~prev_q;
    assign fall  = ~pipe[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_pd_frame_cnt.sv
// Module: counter of serial clock falls inside one frame.
// Does: clears at frame start and counts clock falls while the frame is
//       open, saturating at MAX_CNT.
// Assumes: frame_start and clk_fall never arrive in the same cycle.
module adc_pd_frame_cnt #(
    parameter  int MAX_CNT = 16,
    localparam int CW      = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          frame_open,
    input  logic          clk_fall,
    output logic [CW-1:0] count,
    output logic          full
);

    localparam logic [CW-1:0] LIMIT = CW'(MAX_CNT);

    // Count falls of the serial clock, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   count <= '0;
        else if (frame_start)                         count <= '0;
        else if (frame_open && clk_fall && !full)     count <= count + 1'b1;
    end

    assign full = (count == LIMIT);

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT);

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !frame_start) |=> full);

endmodule

// File: rtl/adc_pd_shifter.sv
// Module: output shift register for the serial data word.
// Does: loads {LEAD_ZEROS zero bits, result} at frame start and moves it
//       one place towards the MSB on every serial clock fall; zeros fill in.
// Assumes: load and shift never arrive in the same cycle.
module adc_pd_shifter #(
    parameter  int DATA_W     = 14,
    parameter  int LEAD_ZEROS = 2,
    localparam int WORD_W     = DATA_W + LEAD_ZEROS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic              sdo_bit
);

    logic [WORD_W-1:0] sreg;

    // Load the new word or advance the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= {{LEAD_ZEROS{1'b0}}, din};
        else if (shift) sreg <= {sreg[WORD_W-2:0], 1'b0};
    end

    assign sdo_bit = sreg[WORD_W-1];

    if (LEAD_ZEROS > 0) begin : g_lead_chk
        assert_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(load) |-> (sdo_bit == 1'b0));
    end

endmodule

// File: rtl/adc_pd_power_fsm.sv
// Module: power-state machine with wake timer.
// Does: picks the next power state from the frame count at frame end,
//       using one window for shutting down and another for waking; counts
//       serial clock falls during a wake and completes it at WAKE_CLKS.
// Assumes: frame_count is the count of the frame that is ending when
//          cs_rise is high.
module adc_pd_power_fsm
    import adc_pd_pkg::*;
#(
    parameter  int PD_LO     = 2,
    parameter  int PD_HI     = 10,
    parameter  int WAKE_MIN  = 10,
    parameter  int WAKE_CLKS = 16,
    parameter  int CW        = 5,
    localparam int WTW       = $clog2(WAKE_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          clk_fall,
    input  logic [CW-1:0] frame_count,
    output pwr_state_t    state
);

    localparam logic [WTW-1:0] WAKE_FULL = WTW'(WAKE_CLKS);

    pwr_state_t     state_nxt;
    logic [WTW-1:0] wake_cnt;
    logic           wake_done;
    logic           in_pd_window;
    logic           wake_held;

    assign wake_done    = (wake_cnt == WAKE_FULL);
    assign in_pd_window = (int'(frame_count) >= PD_LO) && (int'(frame_count) < PD_HI);
    assign wake_held    = (int'(frame_count) >= WAKE_MIN);

    // Wake timer: counts serial clock falls from the start of a wake.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wake_cnt <= '0;
        else if (state == PS_DOWN)              wake_cnt <= '0;
        else if (state == PS_ON)                wake_cnt <= '0;
        else if (clk_fall && !wake_done)        wake_cnt <= wake_cnt + 1'b1;
    end

    // Next-state decision from frame edges, frame count and wake timer.
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_ON: begin
                if (cs_rise && in_pd_window) state_nxt = PS_DOWN;
            end
            PS_DOWN: begin
                if (cs_fall) state_nxt = PS_GUARD;
            end
            PS_GUARD: begin
                if (cs_rise) begin
                    if (!wake_held)     state_nxt = PS_DOWN;
                    else if (wake_done) state_nxt = PS_ON;
                    else                state_nxt = PS_WAKING;
                end
            end
            PS_WAKING: begin
                if (wake_done) state_nxt = PS_ON;
            end
            default: state_nxt = PS_ON;
        endcase
    end

    // State register; reset leaves the part running.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_ON;
        else        state <= state_nxt;
    end

    assert_no_direct_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DOWN) |=> (state == PS_DOWN || state == PS_GUARD));

    assert_guard_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_GUARD && state != PS_GUARD && state != PS_DOWN)
            |-> (int'($past(frame_count)) >= WAKE_MIN));

    assert_wake_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == PS_ON) |-> ($past(wake_cnt) == WAKE_FULL));

    assert_pd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_ON && state == PS_DOWN)
            |-> ($past(cs_rise) && int'($past(frame_count)) >= PD_LO
                 && int'($past(frame_count)) < PD_HI));

    assert_commit_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAKING) |=> (state == PS_WAKING || state == PS_ON));

endmodule

// File: rtl/adc_pd_ctrl.sv
// Module: top of the serial-frame power-mode controller.
// Does: synchronizes frame select and serial clock, counts clock falls
//       per frame, shifts out the result, runs the power-state machine
//       and flags whether the last completed frame carried valid data.
// Assumes: cs_n and sclk each hold for more than SYNC_STAGES+1 clk cycles;
//          result is stable around the frame select falling edge.
module adc_pd_ctrl
    import adc_pd_pkg::*;
#(
    parameter  int DATA_W      = 14,
    parameter  int LEAD_ZEROS  = 2,
    parameter  int SYNC_STAGES = 2,
    parameter  int PD_LO       = 2,
    parameter  int PD_HI       = 10,
    parameter  int WAKE_MIN    = 10,
    parameter  int WAKE_CLKS   = 16,
    localparam int FRAME_CLKS  = DATA_W + LEAD_ZEROS,
    localparam int CW          = $clog2(FRAME_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] result,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              powered,
    output logic              power_down,
    output logic              data_valid
);

    logic [1:0]    s_level, s_rise, s_fall;
    logic          cs_high, cs_fall, cs_rise, clk_fall;
    logic [CW-1:0] frame_count;
    logic          frame_full;
    logic          started_on;
    pwr_state_t    state;

    // Bit 1 carries the frame select, bit 0 the serial clock; both idle high.
    adc_pd_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk}),
        .level (s_level),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    assign cs_high  = s_level[1];
    assign cs_fall  = s_fall[1];
    assign cs_rise  = s_rise[1];
    assign clk_fall = s_fall[0];

    adc_pd_frame_cnt #(.MAX_CNT(FRAME_CLKS)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (cs_fall),
        .frame_open  (!cs_high),
        .clk_fall    (clk_fall),
        .count       (frame_count),
        .full        (frame_full)
    );

    adc_pd_shifter #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cs_fall),
        .shift   (clk_fall && !cs_high),
        .din     (result),
        .sdo_bit (sdo)
    );

    adc_pd_power_fsm #(
        .PD_LO     (PD_LO),
        .PD_HI     (PD_HI),
        .WAKE_MIN  (WAKE_MIN),
        .WAKE_CLKS (WAKE_CLKS),
        .CW        (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .clk_fall    (clk_fall),
        .frame_count (frame_count),
        .state       (state)
    );

    // Remember whether the open frame began with the part fully powered.
    always_ff @(posedge clk) begin
        if (!rst_n)       started_on <= 1'b0;
        else if (cs_fall) started_on <= (state == PS_ON);
    end

    // Data flag: cleared at frame start, set at a complete powered frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_valid <= 1'b0;
        else if (cs_fall) data_valid <= 1'b0;
        else if (cs_rise) data_valid <= started_on && frame_full;
    end

    assign sdo_oe     = !cs_high;
    assign powered    = (state == PS_ON);
    assign power_down = (state == PS_DOWN);

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> ($past(cs_rise) && $past(frame_full)));

    assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !data_valid);

endmodule

// File: tb/adc_pd_ctrl_tb.sv
module adc_pd_ctrl_tb;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [13:0] result = '0;
    logic        sdo, sdo_oe, powered, power_down, data_valid;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model: 0 on, 1 down, 2 guard, 3 waking.
    int m_state = 0;
    int m_wt    = 0;
    int m_valid = 0;

    always #5 clk = ~clk;

    adc_pd_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .result     (result),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .powered    (powered),
        .power_down (power_down),
        .data_valid (data_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_bit(input logic [13:0] r, input int k);
        logic [15:0] w;
        w = {2'b00, r};
        return (k < 16) ? int'(w[15-k]) : 0;
    endfunction

    task automatic model_tick();
        if (m_state == 2 || m_state == 3) begin
            if (m_wt < 16) m_wt++;
        end
        if (m_state == 3 && m_wt == 16) m_state = 0;
    endtask

    task automatic check_state(input string tag);
        chk({tag, " powered"},    int'(powered),    (m_state == 0) ? 1 : 0);
        chk({tag, " power_down"}, int'(power_down), (m_state == 1) ? 1 : 0);
        chk({tag, " data_valid"}, int'(data_valid), m_valid);
    endtask

    task automatic run_frame(input int n, input logic [13:0] r, input string tag);
        bit start_on;
        int cnt;
        start_on = (m_state == 0);
        if (m_state == 1) begin m_state = 2; m_wt = 0; end
        m_valid = 0;
        result = r;
        cs_n = 1'b0;
        waitc(HALF);
        chk("R2 oe during frame", int'(sdo_oe), 1);
        for (int k = 0; k < n; k++) begin
            if (start_on) chk("R3 bit", int'(sdo), exp_bit(r, k));
            sclk = 1'b0;
            waitc(HALF);
            model_tick();
            sclk = 1'b1;
            waitc(HALF);
        end
        if (start_on && n >= 16) chk("R10 tail zero", int'(sdo), 0);
        cs_n = 1'b1;
        cnt = (n > 16) ? 16 : n;
        if (m_state == 0) begin
            if (cnt >= 2 && cnt < 10) m_state = 1;
        end else if (m_state == 2) begin
            if (cnt < 10)        m_state = 1;
            else if (m_wt == 16) m_state = 0;
            else                 m_state = 3;
        end
        m_valid = (start_on && cnt == 16) ? 1 : 0;
        waitc(2 * HALF);
        chk("R2 oe idle", int'(sdo_oe), 0);
        check_state(tag);
    endtask

    task automatic idle_clocks(input int n);
        for (int k = 0; k < n; k++) begin
            sclk = 1'b0;
            waitc(HALF);
            model_tick();
            sclk = 1'b1;
            waitc(HALF);
        end
        waitc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        waitc(4);
        rst_n = 1'b1;
        waitc(4);
        // R1: reset state
        chk("R1 powered", int'(powered), 1);
        chk("R1 power_down", int'(power_down), 0);
        chk("R1 data_valid", int'(data_valid), 0);
        chk("R1 oe", int'(sdo_oe), 0);

        run_frame(16, 14'h2A5B, "R3 full frame");
        run_frame(16, 14'h3FFF, "R6 full frame ones");
        run_frame(1, 14'h1234, "R4 one edge");
        run_frame(0, 14'h1234, "R4 zero edges");
        run_frame(12, 14'h0F0F, "R6 twelve edges");
        run_frame(9, 14'h0001, "R5 nine edges");
        run_frame(8, 14'h0002, "R7 eight-clock burst");
        run_frame(9, 14'h0003, "R7 nine edges asleep");
        run_frame(10, 14'h0004, "R8 wake committed");
        chk("R8 not yet powered", int'(powered), 0);
        idle_clocks(5);
        check_state("R8 wake after 15");
        chk("R8 still waking", int'(powered), 0);
        idle_clocks(1);
        check_state("R8 wake after 16");
        chk("R8 powered at 16", int'(powered), 1);
        run_frame(2, 14'h0005, "R5 two edges");
        run_frame(16, 14'h1111, "R9 wake frame invalid");
        chk("R9 wake frame flag", int'(data_valid), 0);
        run_frame(16, 14'h2222, "R9 next frame valid");
        chk("R9 valid after wake", int'(data_valid), 1);
        run_frame(20, 14'h1ABC, "R10 long frame");
        run_frame(3, 14'h0006, "R5 three edges");
        run_frame(12, 14'h0007, "R11 wake twelve");
        run_frame(3, 14'h0008, "R11 short frame while waking");
        chk("R11 not back down", int'(power_down), 0);
        run_frame(16, 14'h0009, "R11 finish wake");
        run_frame(16, 14'h3A5C, "R9 valid again");

        for (int i = 0; i < 60; i++) begin
            run_frame(int'($urandom_range(0, 20)), 14'($urandom), "R6 random frame");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule